// File: doc/BRIEF.md
# Shadowed SRAM with automatic save and reload

A byte-wide static RAM with a host port in the style of a plain asynchronous SRAM. The port has an address, a bidirectional data bus, and active-low chip enable, output enable and write enable. Behind the RAM sits a shadow array of the same size, modelled as an ordinary register array, that keeps its contents across resets. A reset stands for a power-up. On leaving reset, an internal sequencer reloads every RAM byte from the shadow array. When the supply-low indication rises, the sequencer copies the whole RAM into the shadow array.

Each transfer moves one byte per clock, using a counter that walks from the first address to the last. A store then waits out the rest of a programmable completion time before it returns to idle. A busy output is high while either transfer runs, and during that time the host port is locked out. Holding output enable low vetoes the start of a store. The request stays pending and starts once output enable goes high, provided the supply-low indication is still high.

Top module: `shadow_sram_ctl`

## Requirements
- R1: The memory has 2^AW locations of DW bits (defaults: 2048 locations, 11-bit address, 8-bit data), and each address selects its own byte, including address 0 and the highest address.
- R2: At a rising clock edge with ce_n=0, we_n=0 and busy=0, the byte on dq is written to location addr. With ce_n=1, nothing is written.
- R3: With ce_n=0, oe_n=0, we_n=1 and busy=0, dq drives the contents of location addr in the same cycle.
- R4: dq is released (high impedance) whenever ce_n=1 or oe_n=1.
- R5: After reset is released, busy is high for exactly 2^AW cycles. During that time every RAM location is reloaded from the shadow array, so afterwards the RAM reads back what the last store saved.
- R6: A rising supply-low indication, after a two-stage synchroniser, starts a store. The store copies every RAM location into the shadow array and holds busy high for max(STORE_CYCLES, 2^AW) cycles. The default STORE_CYCLES of 125000 equals 2.5 ms at 50 MHz.
- R7: A store never starts while oe_n=0. A store requested during oe_n=0 starts after oe_n returns high if supply-low is still high, and is dropped if supply-low falls first.
- R8: One supply-low event produces exactly one store. Supply-low held high after that store starts no further store.
- R9: While busy=1, host writes are ignored and dq is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release stands for power-up |
| sup_low | input | 1 | Supply-low indication, asynchronous |
| addr | input | AW | Host byte address |
| dq | inout | DW | Host data bus |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low also vetoes a store |
| we_n | input | 1 | Write enable, active low |
| busy | output | 1 | High during reload and store |

## Verification
The assertions assume that supply-low changes slowly compared with the clock, so that each event passes through the synchroniser as one clean rising edge. They also assume that reset is held for at least one clock edge. The bench changes supply-low only a short time after a clock edge and leaves it stable for many cycles between changes. It keeps STORE_CYCLES small enough that several stores and reloads fit in a short run. Host accesses happen only between transfers, except for the accesses that deliberately probe the lockout.

// File: rtl/shadow_sram_ctl.sv
module shadow_sram_ctl #(
  parameter int AW           = 11,
  parameter int DW           = 8,
  parameter int STORE_CYCLES = 125000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_low,
  input  logic [AW-1:0] addr,
  inout  wire  [DW-1:0] dq,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  output logic          busy
);
  localparam int DEPTH     = 1 << AW;
  localparam int STORE_LEN = (STORE_CYCLES > DEPTH) ? STORE_CYCLES : DEPTH;
  localparam int TW        = $clog2(STORE_LEN + 1);

  typedef enum logic [1:0] {IDLE, RECALL, STORE} mode_t;

  mode_t         mode;
  logic [TW-1:0] tick;
  logic [2:0]    sync;
  logic          pend;
  logic [DW-1:0] ram    [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  wire          lvl    = sync[1];
  wire          rise   = sync[1] & ~sync[2];
  wire          want   = (rise | pend) & lvl;
  wire          go     = (mode == IDLE) & want & oe_n;
  wire [AW-1:0] ptr    = tick[AW-1:0];
  wire          wr_en  = ~busy & ~ce_n & ~we_n;
  wire          rd_en  = ~busy & ~ce_n & ~oe_n & we_n;

  assign busy = (mode != IDLE);
  assign dq   = rd_en ? ram[addr] : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= '0;
      mode <= RECALL;
      tick <= '0;
      pend <= 1'b0;
    end else begin
      sync <= {sync[1:0], sup_low};
      if (go || !lvl)
        pend <= 1'b0;
      else if (rise)
        pend <= 1'b1;
      unique case (mode)
        IDLE: begin
          tick <= '0;
          if (go) mode <= STORE;
        end
        RECALL: begin
          tick <= tick + 1'b1;
          if (tick == TW'(DEPTH - 1)) begin
            mode <= IDLE;
            tick <= '0;
          end
        end
        STORE: begin
          tick <= tick + 1'b1;
          if (tick == TW'(STORE_LEN - 1)) begin
            mode <= IDLE;
            tick <= '0;
          end
        end
        default: mode <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mode == RECALL)
      ram[ptr] <= shadow[ptr];
    else if (wr_en)
      ram[addr] <= dq;
    if (mode == STORE && tick < TW'(DEPTH))
      shadow[ptr] <= ram[ptr];
  end
endmodule

// File: rtl/shadow_sram_chk.sv
module shadow_sram_chk #(
  parameter int DEPTH     = 2048,
  parameter int STORE_LEN = 125000
) (
  input logic clk,
  input logic rst_n,
  input logic oe_n,
  input logic busy,
  input logic sup_lvl,
  input logic sup_rise
);
  logic [31:0] run;
  logic        busy_q, first_done, armed;
  wire         started = busy & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= '0;
      busy_q     <= 1'b1;
      first_done <= 1'b0;
      armed      <= 1'b0;
    end else begin
      busy_q <= busy;
      run    <= busy ? run + 1 : '0;
      if (busy_q && !busy) first_done <= 1'b1;
      if (started) armed <= sup_rise;
      else if (sup_rise) armed <= 1'b1;
    end
  end

  // R7
  veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(oe_n));

  // R5 R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == (first_done ? 32'(STORE_LEN) : 32'(DEPTH))));

  // R8
  store_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> armed);

  // R7
  store_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sup_lvl));
endmodule

bind shadow_sram_ctl shadow_sram_chk #(.DEPTH(DEPTH), .STORE_LEN(STORE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .busy(busy),
  .sup_lvl(lvl), .sup_rise(rise)
);

// File: tb/test_shadow_sram_ctl.sv
module test_shadow_sram_ctl;
  localparam int AW = 11, DW = 8, SC = 2500, DEPTH = 1 << AW;

  logic          clk = 0, rst_n = 0, sup_low = 0;
  logic          ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] tb_d = '0;
  logic          tb_en = 0;
  wire  [DW-1:0] dq;
  wire           busy;

  assign dq = tb_en ? tb_d : {DW{1'bz}};

  shadow_sram_ctl #(.AW(AW), .DW(DW), .STORE_CYCLES(SC)) i_shadow_sram_ctl (
    .clk(clk), .rst_n(rst_n), .sup_low(sup_low), .addr(addr), .dq(dq),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .busy(busy));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] expq[$];
  string         tagq[$];
  logic          rd_req = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_req && expq.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(dq === e, t, int'(dq), int'(e));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'(a) ^ DW'(8'h3C + k) ^ DW'((a >> 8) << 5);
  endfunction

  task automatic host_write(input int a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    addr = AW'(a); tb_d = d; tb_en = 1; oe_n = 1; ce_n = 0; we_n = 0;
    @(posedge clk); #1;
    ce_n = 1; we_n = 1; tb_en = 0;
  endtask

  task automatic host_write_nce(input int a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    addr = AW'(a); tb_d = d; tb_en = 1; oe_n = 1; ce_n = 1; we_n = 0;
    @(posedge clk); #1;
    we_n = 1; tb_en = 0;
  endtask

  task automatic host_read(input int a, input logic [DW-1:0] e, input string tag);
    @(posedge clk); #1;
    addr = AW'(a); tb_en = 0; we_n = 1; ce_n = 0; oe_n = 0;
    expq.push_back(e); tagq.push_back(tag); rd_req = 1;
    @(negedge clk); #1;
    rd_req = 0; ce_n = 1; oe_n = 1;
  endtask

  task automatic busy_len(output int n);
    int guard = 0;
    n = 0;
    while (!busy && guard < 100) begin @(negedge clk); guard++; end
    while (busy && n < 200000) begin n++; @(negedge clk); end
  endtask

  task automatic power_up(input string tag);
    int n;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b1, {tag, " busy after reset"}, int'(busy), 1);
    busy_len(n);
    chk(n == DEPTH, {tag, " reload length"}, n, DEPTH);
  endtask

  int addrs[12] = '{0, 1, 2, 5, 7, 100, 255, 256, 1024, 1500, 2046, 2047};

  initial begin
    int n, quiet;
    // R5: first power-up
    power_up("R5");

    // R1 R2 R3: write then read a spread of addresses
    foreach (addrs[i]) host_write(addrs[i], pat(addrs[i], 0));
    host_write(7, 8'h5A);
    foreach (addrs[i])
      if (addrs[i] != 7) host_read(addrs[i], pat(addrs[i], 0), "R1 R3 readback");
    host_read(7, 8'h5A, "R3 read addr7");
    host_read(0, pat(0, 0), "R1 addr0 distinct");
    host_read(2047, pat(2047, 0), "R1 top addr distinct");

    // R2: chip enable high blocks the write
    host_write_nce(100, 8'hC3);
    host_read(100, pat(100, 0), "R2 ce_n high no write");

    // R4: bus released with oe_n high, then with ce_n high
    @(posedge clk); #1;
    addr = 7; tb_d = 8'hA5; tb_en = 1; ce_n = 0; oe_n = 1; we_n = 1;
    @(negedge clk);
    chk(dq === 8'hA5, "R4 oe_n high releases bus", int'(dq), 8'hA5);
    #1 ce_n = 1; oe_n = 0;
    @(negedge clk);
    chk(dq === 8'hA5, "R4 ce_n high releases bus", int'(dq), 8'hA5);
    #1 tb_en = 0; oe_n = 1;

    // R7: store request held off while oe_n is low
    @(posedge clk); #1;
    ce_n = 0; oe_n = 0; we_n = 1; addr = 0;
    sup_low = 1;
    quiet = 0;
    repeat (20) begin @(negedge clk); if (busy) quiet++; end
    chk(quiet == 0, "R7 no store while oe_n low", quiet, 0);
    #1 oe_n = 1; ce_n = 1;

    // R6: pending store runs for the full completion time
    while (!busy) @(negedge clk);
    // R9: write and read attempts during the store
    #1 addr = 5; tb_d = 8'hEE; tb_en = 1; ce_n = 0; we_n = 0;
    @(negedge clk);
    #1 we_n = 1; addr = 7; tb_d = 8'hA5; oe_n = 0;
    @(negedge clk);
    chk(dq === 8'hA5, "R9 bus released while busy", int'(dq), 8'hA5);
    #1 tb_en = 0; ce_n = 1; oe_n = 1;
    n = 2;
    while (busy && n < 10000) begin n++; @(negedge clk); end
    chk(n == SC, "R6 store length", n, SC);
    host_read(5, pat(5, 0), "R9 write during store ignored");

    // R8: supply-low still high, no second store
    quiet = 0;
    repeat (3000) begin @(negedge clk); if (busy) quiet++; end
    chk(quiet == 0, "R8 single store per event", quiet, 0);
    #1 sup_low = 0;
    repeat (10) @(posedge clk);

    // R7: pending request dropped when supply-low falls first
    @(posedge clk); #1;
    ce_n = 0; oe_n = 0; sup_low = 1;
    repeat (10) @(posedge clk);
    #1 sup_low = 0;
    repeat (10) @(posedge clk);
    #1 oe_n = 1; ce_n = 1;
    quiet = 0;
    repeat (20) begin @(negedge clk); if (busy) quiet++; end
    chk(quiet == 0, "R7 pending store cancelled", quiet, 0);

    // overwrite RAM, confirm, then power-cycle and expect the saved image
    foreach (addrs[i]) host_write(addrs[i], pat(addrs[i], 7));
    host_read(1024, pat(1024, 7), "R2 overwrite");
    power_up("R5 second");
    foreach (addrs[i])
      if (addrs[i] != 7) host_read(addrs[i], pat(addrs[i], 0), "R5 R6 reload of stored image");
    host_read(7, 8'h5A, "R6 stored addr7");

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule